// File: doc/BRIEF.md
# Next-Instruction Pointer Substitution Unit

This unit sits in the decode path of a processor and carries out a prefix operation. The prefix names one 32-bit register whose contents hold three packed 9-bit pointers: a source pointer in bits [8:0], a destination pointer in bits [17:9] and a write-redirect pointer in bits [31:23]. A 9-bit mode value gives each pointer its own 3-bit code, laid out as {redirect, destination, source}. The three codes share one code table.

While the prefix is presented, the unit works out the pointer values to substitute and the updated register word. It offers that word for write-back in the same cycle and keeps the substitution pending. The next instruction that issues has its source field (bits [8:0]) and destination field (bits [17:9]) replaced as the codes request. If the redirect code is active, the unit also supplies an alternative write-back address for that instruction's result. The pending state then clears, so exactly one instruction is affected.

Top module: `ptrsub_unit`

## Requirements
- R1: A lane code of 001 replaces its field of the next issued instruction with the current pointer (source pointer bits [8:0] into instruction bits [8:0], destination pointer bits [17:9] into instruction bits [17:9]) and leaves that pointer unchanged in the written-back word.
- R2: Lane codes 000, 010 and 011 leave the corresponding instruction field unaltered and keep the pointer at its old value in the written-back word.
- R3: Code 100 substitutes the current pointer and stores pointer+1. Code 101 substitutes the current pointer and stores pointer-1.
- R4: Code 110 substitutes pointer+1 and stores pointer+1. Code 111 substitutes pointer-1 and stores pointer-1.
- R5: When the redirect code (mode bits [8:6]) is 001 or 1xx, the next issued instruction raises redir_en, and redir_addr carries the redirect pointer (register bits [31:23]) as modified by that code. Otherwise redir_en is 0 and redir_addr is 0.
- R6: Pointer arithmetic wraps modulo 512 inside each 9-bit field (0x1FF+1 gives 0x000, 0x000-1 gives 0x1FF), and no carry or borrow reaches a neighbouring field.
- R7: The substitution applies only to the first instruction issued after the prefix. After that issue, and after a reset, instructions pass unmodified and redir_en stays 0.
- R8: wb_en is 1 in the prefix cycle exactly when at least one of the three codes is in the range 100 to 111. wb_data carries register bits [22:18] unchanged and each pointer field at its stored value.
- R9: Instruction bits [31:18] always pass to the output unchanged.
- R10: A second prefix that arrives before any instruction issues replaces the pending substitution of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_valid | input | 1 | Prefix operation presented this cycle |
| pfx_reg | input | 32 | Packed pointer register value |
| pfx_mode | input | 9 | Per-pointer codes {redirect, destination, source} |
| insn_valid | input | 1 | Following instruction issues this cycle |
| insn_word | input | 32 | Following instruction word |
| out_insn | output | 32 | Instruction word with substituted fields |
| redir_en | output | 1 | Write result to redir_addr instead of its own destination |
| redir_addr | output | 9 | Write-redirect address |
| wb_en | output | 1 | Write updated pointer word back to the register |
| wb_data | output | 32 | Updated pointer word |

## Verification
The bench drives pointers sitting at 0x1FF and 0x000 under each increment and decrement code. A design that let a carry leak across a field, or that did not wrap, would corrupt a neighbouring pointer or the bits [22:18] in wb_data. The pre- and post-step codes are mixed within one prefix, so a design that swapped substitute-before and substitute-after would show an off-by-one field in out_insn. The reserved codes are run beside a stepping lane: a design that stepped or substituted on them would change wb_data or the instruction. Three further tests cover persistence. One checks a second instruction after the prefix. One sends a prefix followed by a reset. One sends two back-to-back prefixes. A unit that held stale state would modify instructions it should leave alone.

// File: rtl/ptrsub_pkg.sv
// Package: shared widths and lane result type for the pointer substitution unit.
// Assumes pointers are PW bits wide and packed into an RW-bit register.
package ptrsub_pkg;
    parameter int PW    = 9;             // pointer and field width
    parameter int RW    = 32;            // register and instruction width
    parameter int CW    = 3;             // code width per lane
    parameter int NL    = 3;             // lanes: 0 source, 1 destination, 2 redirect
    parameter int RED_LO = RW - PW;      // lowest bit of redirect pointer

    // Result of evaluating one lane's code against its pointer
    typedef struct packed {
        logic          sub;   // substitute into next instruction
        logic [PW-1:0] val;   // value to substitute
        logic [PW-1:0] nxt;   // value to store back
        logic          step;  // code changes the pointer
    } lane_res_t;

    // Low bit of lane i inside the pointer register
    function automatic int lane_lo(int i);
        return (i == NL - 1) ? RED_LO : i * PW;
    endfunction
endpackage

// File: rtl/ptrsub_lane.sv
// Module: one pointer lane. Decodes a 3-bit code and produces the value to
// substitute, the value to store, and flags. Purely combinational; arithmetic
// wraps within PW bits.
module ptrsub_lane
    import ptrsub_pkg::*;
(
    input  logic [CW-1:0] code,
    input  logic [PW-1:0] ptr,
    output lane_res_t     res
);
    logic [PW-1:0] inc, dec;

    // Neighbour values, wrapping inside the field
    always_comb begin
        inc = ptr + PW'(1);
        dec = ptr - PW'(1);
    end

    // Decode the code table
    always_comb begin
        res.sub  = 1'b0;
        res.val  = ptr;
        res.nxt  = ptr;
        res.step = 1'b0;
        case (code)
            3'b001: res.sub = 1'b1;
            3'b100: begin res.sub = 1'b1; res.nxt = inc; res.step = 1'b1; end
            3'b101: begin res.sub = 1'b1; res.nxt = dec; res.step = 1'b1; end
            3'b110: begin res.sub = 1'b1; res.val = inc; res.nxt = inc; res.step = 1'b1; end
            3'b111: begin res.sub = 1'b1; res.val = dec; res.nxt = dec; res.step = 1'b1; end
            default: ;
        endcase
    end

    // Stepped pointer differs from the old one by exactly one
    // R6
    always_comb begin
        if (res.step)
            lane_step_chk: assert ((PW'(res.nxt - ptr) == PW'(1)) || (PW'(ptr - res.nxt) == PW'(1)));
    end
endmodule

// File: rtl/ptrsub_hold.sv
// Module: pending substitution register. Loads lane results on a prefix,
// clears when an instruction issues, and clears on reset. A prefix wins over
// a same-cycle issue.
module ptrsub_hold
    import ptrsub_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               consume,
    input  lane_res_t [NL-1:0] d_in,
    output lane_res_t [NL-1:0] q_out
);
    lane_res_t [NL-1:0] q;

    // Hold, replace or drop the pending substitution
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d_in;
        else if (consume)
            q <= '0;
    end

    assign q_out = q;

    logic any_pend;
    always_comb begin
        any_pend = 1'b0;
        for (int i = 0; i < NL; i++) any_pend = any_pend | q[i].sub;
    end

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !load) |=> !any_pend);
endmodule

// File: rtl/ptrsub_unit.sv
// Module: top of the next-instruction pointer substitution unit. Evaluates
// three lanes on a prefix, offers the updated register in the same cycle, and
// rewrites the next issued instruction from the pending state.
// Assumes source field [PW-1:0], destination field [2*PW-1:PW] of the instruction.
module ptrsub_unit
    import ptrsub_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pfx_valid,
    input  logic [RW-1:0] pfx_reg,
    input  logic [NL*CW-1:0] pfx_mode,
    input  logic          insn_valid,
    input  logic [RW-1:0] insn_word,
    output logic [RW-1:0] out_insn,
    output logic          redir_en,
    output logic [PW-1:0] redir_addr,
    output logic          wb_en,
    output logic [RW-1:0] wb_data
);
    lane_res_t [NL-1:0] now_res;
    lane_res_t [NL-1:0] pend;

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            ptrsub_lane u_lane (
                .code (pfx_mode[g*CW +: CW]),
                .ptr  (pfx_reg[lane_lo(g) +: PW]),
                .res  (now_res[g])
            );
        end
    endgenerate

    ptrsub_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pfx_valid),
        .consume (insn_valid),
        .d_in    (now_res),
        .q_out   (pend)
    );

    // Build the write-back word from stored pointer values
    always_comb begin
        wb_data = pfx_reg;
        wb_en   = 1'b0;
        for (int i = 0; i < NL; i++) begin
            wb_data[lane_lo(i) +: PW] = now_res[i].nxt;
            wb_en = wb_en | now_res[i].step;
        end
        wb_en = wb_en & pfx_valid;
    end

    // Rewrite source and destination fields of the issued instruction
    always_comb begin
        out_insn = insn_word;
        for (int i = 0; i < NL - 1; i++)
            if (pend[i].sub) out_insn[i*PW +: PW] = pend[i].val;
    end

    // Redirect address for the issued instruction
    always_comb begin
        redir_en   = insn_valid & pend[NL-1].sub;
        redir_addr = redir_en ? pend[NL-1].val : '0;
    end

    // R9
    always_comb begin
        opcode_pass_chk: assert (out_insn[RW-1:2*PW] == insn_word[RW-1:2*PW]);
    end

    // R8
    wb_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data != pfx_reg));
endmodule

// File: tb/sim_ptrsub_unit.sv
module sim_ptrsub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_valid = 1'b0;
    logic [31:0] pfx_reg = '0;
    logic [8:0]  pfx_mode = '0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] out_insn;
    logic        redir_en;
    logic [8:0]  redir_addr;
    logic        wb_en;
    logic [31:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptrsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_reg(pfx_reg),
        .pfx_mode(pfx_mode), .insn_valid(insn_valid), .insn_word(insn_word),
        .out_insn(out_insn), .redir_en(redir_en), .redir_addr(redir_addr),
        .wb_en(wb_en), .wb_data(wb_data)
    );

    localparam int NV = 8;
    localparam logic [8:0]  VR [NV] = '{9'h055, 9'h001, 9'h1FF, 9'h0C0, 9'h000, 9'h100, 9'h07F, 9'h1AA};
    localparam logic [8:0]  VD [NV] = '{9'h0A3, 9'h1FF, 9'h012, 9'h1FF, 9'h033, 9'h000, 9'h0EE, 9'h044};
    localparam logic [8:0]  VS [NV] = '{9'h111, 9'h000, 9'h000, 9'h1FF, 9'h0BB, 9'h1FF, 9'h020, 9'h1FF};
    localparam logic [4:0]  VM [NV] = '{5'h15, 5'h0A, 5'h1F, 5'h00, 5'h11, 5'h0E, 5'h03, 5'h1B};
    localparam logic [8:0]  VC [NV] = '{9'b000_001_001, 9'b000_100_101, 9'b110_000_111, 9'b001_110_100,
                                        9'b111_010_011, 9'b101_111_110, 9'b100_001_000, 9'b010_011_100};
    localparam logic [31:0] VI [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hFFFFFFFF, 32'h00000000,
                                        32'hA5A5A5A5, 32'h0F0F0F0F, 32'hCAFEF00D, 32'h87654321};

    // Expected lane behaviour from the code table
    task automatic model_lane(input logic [2:0] c, input logic [8:0] p,
                              output bit sub, output logic [8:0] v, output logic [8:0] n, output bit st);
        sub = 0; v = p; n = p; st = 0;
        if (c == 3'b001) sub = 1;
        else if (c == 3'b100) begin sub = 1; n = p + 9'd1; st = 1; end
        else if (c == 3'b101) begin sub = 1; n = p - 9'd1; st = 1; end
        else if (c == 3'b110) begin sub = 1; v = p + 9'd1; n = v; st = 1; end
        else if (c == 3'b111) begin sub = 1; v = p - 9'd1; n = v; st = 1; end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_prefix(input logic [31:0] r, input logic [8:0] m);
        @(negedge clk);
        insn_valid = 0; pfx_valid = 1; pfx_reg = r; pfx_mode = m;
    endtask

    task automatic send_insn(input logic [31:0] w);
        @(negedge clk);
        pfx_valid = 0; insn_valid = 1; insn_word = w;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R7 reset state: instruction passes, no redirect, no write-back
        send_insn(32'h13579BDF);
        #1;
        chk("R7 reset out_insn", out_insn, 32'h13579BDF);
        chk("R7 reset redir_en", {31'd0, redir_en}, 32'd0);
        chk("R8 reset wb_en", {31'd0, wb_en}, 32'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R8 R9
        for (int k = 0; k < NV; k++) begin
            logic [31:0] r, exp_ins, exp_wb;
            bit s0, s1, s2, t0, t1, t2;
            logic [8:0] v0, v1, v2, n0, n1, n2;
            r = {VR[k], VM[k], VD[k], VS[k]};
            model_lane(VC[k][2:0], VS[k], s0, v0, n0, t0);
            model_lane(VC[k][5:3], VD[k], s1, v1, n1, t1);
            model_lane(VC[k][8:6], VR[k], s2, v2, n2, t2);
            exp_wb  = {n2, VM[k], n1, n0};
            exp_ins = {VI[k][31:18], s1 ? v1 : VI[k][17:9], s0 ? v0 : VI[k][8:0]};
            send_prefix(r, VC[k]);
            #1;
            chk($sformatf("R8 vec%0d wb_en", k), {31'd0, wb_en}, {31'd0, (t0 | t1 | t2)});
            if (t0 | t1 | t2)
                chk($sformatf("R6 R3 R4 R2 vec%0d wb_data", k), wb_data, exp_wb);
            send_insn(VI[k]);
            #1;
            chk($sformatf("R1 R2 R9 vec%0d out_insn", k), out_insn, exp_ins);
            chk($sformatf("R5 vec%0d redir", k), {22'd0, redir_en, redir_addr},
                {22'd0, s2, s2 ? v2 : 9'd0});
        end

        // R7: second instruction after a prefix is untouched
        send_prefix({9'h1F0, 5'h00, 9'h0F0, 9'h00F}, 9'b001_001_001);
        send_insn(32'hAAAAAAAA);
        #1;
        chk("R7 first insn", out_insn, {14'h2AAA, 9'h0F0, 9'h00F});
        send_insn(32'hBBBBBBBB);
        #1;
        chk("R7 second insn", out_insn, 32'hBBBBBBBB);
        chk("R7 second redir", {31'd0, redir_en}, 32'd0);

        // R7: reset drops a pending substitution
        send_prefix({9'h1F0, 5'h00, 9'h0F0, 9'h00F}, 9'b001_001_001);
        @(negedge clk);
        pfx_valid = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        send_insn(32'hCCCCCCCC);
        #1;
        chk("R7 after reset out_insn", out_insn, 32'hCCCCCCCC);
        chk("R7 after reset redir", {31'd0, redir_en}, 32'd0);

        // R10: second prefix replaces the first
        send_prefix({9'h011, 5'h00, 9'h022, 9'h033}, 9'b001_001_001);
        send_prefix({9'h044, 5'h00, 9'h055, 9'h066}, 9'b000_000_001);
        send_insn(32'h00000000);
        #1;
        chk("R10 replaced out_insn", out_insn, {23'd0, 9'h066});
        chk("R10 replaced redir", {31'd0, redir_en}, 32'd0);

        @(negedge clk);
        insn_valid = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule